// File: doc/BRIEF.md
# Floating-Point Issue Hazard and Write-Port Controller

This block is the issue-side control for a small in-order core that keeps its floating-point registers in a file of their own. Next to it run a fixed-latency floating-point pipe and one iterative divide/square-root unit. The fixed pipe is longer than the integer execute path. The block records the destination register of every operation still in flight. From that record it decides whether the instruction presented at issue may go this cycle.

It holds back four kinds of issue. The first is a floating-point instruction that reads a register still waiting for its result. The second is one that would write a register with a write still pending. The third is a move between the integer and floating-point domains while any floating-point work is unfinished. The fourth is a second divide while the divider is occupied. It also owns the single write port of the floating-point register file. When a fixed-pipe result and a divider result arrive together, the fixed result is written first. The divider result is parked for a cycle, and issue is stalled while it waits. Integer instructions are never compared against floating-point destinations.

Top module: `fp_issue_ctrl`

## Requirements
- R1: After reset no operation is in flight: `wb_en` is 0, and an instruction presented at issue is not stalled.
- R2: An issue of kind 0 (integer) is never stalled by the read, write-order or move checks, whatever its register fields hold.
- R3: A kind 1 (fixed-pipe FP op) instruction accepted in cycle t writes its `issue_rd` in cycle t+FIX_LAT. In that cycle `wb_en`=1 and `wb_from_div`=0.
- R4: An instruction of kind 1 or 2 stalls with `stall_raw` when any enabled source matches the destination of an in-flight operation. Source i is rs1, rs2 or rs3 and is enabled by `issue_src_use` bit i (bit 0 is rs1, bit 2 is rs3). An in-flight operation is one still in the fixed pipe, including the cycle of its write, or a pending divide. A disabled source is ignored.
- R5: An instruction of kind 1 or 2 stalls with `stall_waw` when its `issue_rd` matches the destination of any in-flight operation.
- R6: A kind 3 (domain move) instruction stalls with `stall_move` while any fixed-pipe entry is valid or a divide result is still unwritten.
- R7: If `div_done` arrives in a cycle with a fixed-pipe write, the fixed result is written and the divider result waits. The divider result is written in the first later cycle that has no fixed-pipe write. `stall_wb` stalls issue in the collision cycle and while the result waits.
- R8: A cycle in which the presented instruction is stalled enters no operation into the fixed pipe, so it produces no write FIX_LAT cycles later.
- R9: A kind 2 (divide/sqrt) instruction that is accepted raises `div_start` in the same cycle. A further kind 2 issue stalls with `stall_div` until the divider result is written. A `div_done` with no collision writes the held destination in that same cycle with `wb_from_div`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is presented at issue |
| issue_kind | input | 2 | 0 integer, 1 fixed FP op, 2 divide/sqrt, 3 domain move |
| issue_rs1 | input | 5 | FP source register 1 |
| issue_rs2 | input | 5 | FP source register 2 |
| issue_rs3 | input | 5 | FP source register 3 |
| issue_src_use | input | 3 | Source enables, bit 0 rs1 to bit 2 rs3 |
| issue_rd | input | 5 | FP destination register |
| div_done | input | 1 | Divide/sqrt unit finishes this cycle |
| stall | output | 1 | Issue is held this cycle |
| stall_raw | output | 1 | Stall cause: pending source |
| stall_waw | output | 1 | Stall cause: pending destination |
| stall_move | output | 1 | Stall cause: domain move drain |
| stall_div | output | 1 | Stall cause: divider occupied |
| stall_wb | output | 1 | Stall cause: write-port collision |
| div_start | output | 1 | Launch the divide/sqrt unit |
| wb_en | output | 1 | FP register file write enable |
| wb_rd | output | 5 | FP register file write address |
| wb_from_div | output | 1 | Write data is selected from the divider |

## Verification
The bench builds the block with FIX_LAT=4 and 5-bit register addresses. With this depth, a dependent instruction behind a producer is stalled for exactly four cycles, so the count of stalled cycles is a precise check of the tracking window. The short pipe lets a divider finish land on a single fixed write or on two back-to-back writes within a few cycles. That exercises both the one-cycle wait and the longer wait for a free slot. A scoreboard predicts every register-file write by cycle, destination and source, and flags any write it did not predict.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  localparam int unsigned REG_AW  = 5;
  localparam int unsigned SRC_N   = 3;

  typedef enum logic [1:0] {
    K_INT   = 2'd0,
    K_FPOP  = 2'd1,
    K_FPDIV = 2'd2,
    K_MOVE  = 2'd3
  } kind_t;

  typedef struct packed {
    logic              v;
    logic [REG_AW-1:0] rd;
  } slot_t;

  function automatic logic reg_match(input logic en, input logic pend,
                                     input logic [REG_AW-1:0] a,
                                     input logic [REG_AW-1:0] b);
    return en && pend && (a == b);
  endfunction

  function automatic logic is_fp_kind(input kind_t k);
    return (k == K_FPOP) || (k == K_FPDIV);
  endfunction

endpackage

// File: rtl/fpc_track.sv
module fpc_track
  import fpc_pkg::*;
#(
  parameter int unsigned LAT = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [REG_AW-1:0]            push_rd,
  input  logic [SRC_N-1:0][REG_AW-1:0] q_rs,
  input  logic [SRC_N-1:0]             q_use,
  input  logic [REG_AW-1:0]            q_rd,
  output logic [SRC_N-1:0]             src_hit,
  output logic                         rd_hit,
  output logic                         any_v,
  output logic                         wb_v,
  output logic [REG_AW-1:0]            wb_rd
);

  slot_t pipe [LAT];

  logic [LAT-1:0][SRC_N-1:0] slot_src_hit;
  logic [LAT-1:0]            slot_rd_hit;
  logic [LAT-1:0]            slot_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < LAT; k++) pipe[k] <= '0;
    end else begin
      pipe[0] <= '{v: push, rd: push_rd};
      for (int k = 1; k < LAT; k++) pipe[k] <= pipe[k-1];
    end
  end

  for (genvar k = 0; k < LAT; k++) begin : g_slot
    assign slot_v[k]      = pipe[k].v;
    assign slot_rd_hit[k] = reg_match(1'b1, pipe[k].v, pipe[k].rd, q_rd);
    for (genvar i = 0; i < SRC_N; i++) begin : g_src
      assign slot_src_hit[k][i] = reg_match(q_use[i], pipe[k].v, pipe[k].rd, q_rs[i]);
    end
  end

  always_comb begin
    src_hit = '0;
    for (int k = 0; k < LAT; k++) src_hit = src_hit | slot_src_hit[k];
  end

  assign rd_hit = |slot_rd_hit;
  assign any_v  = |slot_v;
  assign wb_v   = pipe[LAT-1].v;
  assign wb_rd  = pipe[LAT-1].rd;

  // R3: a write from the fixed pipe always comes from an entry that was in flight the cycle before
  assert_wb_had_inflight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_v |-> $past(any_v));

endmodule

// File: rtl/fpc_wbarb.sv
module fpc_wbarb
  import fpc_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [REG_AW-1:0]            start_rd,
  input  logic                         done,
  input  logic                         fix_v,
  input  logic [REG_AW-1:0]            fix_rd,
  input  logic [SRC_N-1:0][REG_AW-1:0] q_rs,
  input  logic [SRC_N-1:0]             q_use,
  input  logic [REG_AW-1:0]            q_rd,
  output logic                         busy,
  output logic [SRC_N-1:0]             src_hit,
  output logic                         rd_hit,
  output logic                         hold_v,
  output logic                         collide,
  output logic                         wb_en,
  output logic [REG_AW-1:0]            wb_rd,
  output logic                         wb_from_div
);

  logic [REG_AW-1:0] div_rd_q;
  logic              div_write;

  assign collide   = done && fix_v;
  assign div_write = (done || hold_v) && !fix_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      hold_v   <= 1'b0;
      div_rd_q <= '0;
    end else begin
      if (div_write) busy <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        div_rd_q <= start_rd;
      end
      if (collide)        hold_v <= 1'b1;
      else if (div_write) hold_v <= 1'b0;
    end
  end

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    assign src_hit[i] = reg_match(q_use[i], busy, div_rd_q, q_rs[i]);
  end
  assign rd_hit = reg_match(1'b1, busy, div_rd_q, q_rd);

  assign wb_en       = fix_v || div_write;
  assign wb_rd       = fix_v ? fix_rd : div_rd_q;
  assign wb_from_div = div_write;

  // R7: the losing divider result is parked with its destination intact
  assert_loser_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> (hold_v && busy && $stable(div_rd_q)));

  // R7: the port never carries the divider while the fixed pipe writes
  assert_fixed_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fix_v |-> !wb_from_div);

  // R9: the divider is launched only when it is free
  assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: rtl/fpc_hazard.sv
module fpc_hazard
  import fpc_pkg::*;
#(
  parameter int unsigned NSRC = 3
) (
  input  logic            issue_valid,
  input  kind_t           kind,
  input  logic [NSRC-1:0] trk_src_hit,
  input  logic            trk_rd_hit,
  input  logic            trk_any,
  input  logic [NSRC-1:0] div_src_hit,
  input  logic            div_rd_hit,
  input  logic            div_busy,
  input  logic            hold_v,
  input  logic            collide,
  output logic            stall_raw,
  output logic            stall_waw,
  output logic            stall_move,
  output logic            stall_div,
  output logic            stall_wb,
  output logic            stall,
  output logic            accept_fix,
  output logic            accept_div
);

  logic fp_k;
  assign fp_k = is_fp_kind(kind);

  always_comb begin
    stall_raw  = issue_valid && fp_k && (|(trk_src_hit | div_src_hit));
    stall_waw  = issue_valid && fp_k && (trk_rd_hit || div_rd_hit);
    stall_move = issue_valid && (kind == K_MOVE) && (trk_any || div_busy);
    stall_div  = issue_valid && (kind == K_FPDIV) && div_busy;
    stall_wb   = issue_valid && (hold_v || collide);
    stall      = stall_raw || stall_waw || stall_move || stall_div || stall_wb;
    accept_fix = issue_valid && !stall && (kind == K_FPOP);
    accept_div = issue_valid && !stall && (kind == K_FPDIV);
  end

endmodule

// File: rtl/fp_issue_ctrl.sv
module fp_issue_ctrl
  import fpc_pkg::*;
#(
  parameter int unsigned FIX_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [1:0]        issue_kind,
  input  logic [REG_AW-1:0] issue_rs1,
  input  logic [REG_AW-1:0] issue_rs2,
  input  logic [REG_AW-1:0] issue_rs3,
  input  logic [SRC_N-1:0]  issue_src_use,
  input  logic [REG_AW-1:0] issue_rd,
  input  logic              div_done,
  output logic              stall,
  output logic              stall_raw,
  output logic              stall_waw,
  output logic              stall_move,
  output logic              stall_div,
  output logic              stall_wb,
  output logic              div_start,
  output logic              wb_en,
  output logic [REG_AW-1:0] wb_rd,
  output logic              wb_from_div
);

  kind_t                        kind;
  logic [SRC_N-1:0][REG_AW-1:0] q_rs;
  logic [SRC_N-1:0]             trk_src_hit, div_src_hit;
  logic                         trk_rd_hit, div_rd_hit, trk_any;
  logic                         fix_v;
  logic [REG_AW-1:0]            fix_rd;
  logic                         div_busy, hold_v, collide;
  logic                         accept_fix, accept_div;

  assign kind = kind_t'(issue_kind);
  assign q_rs = {issue_rs3, issue_rs2, issue_rs1};

  fpc_track #(.LAT(FIX_LAT)) u_track (
    .clk(clk), .rst_n(rst_n),
    .push(accept_fix), .push_rd(issue_rd),
    .q_rs(q_rs), .q_use(issue_src_use), .q_rd(issue_rd),
    .src_hit(trk_src_hit), .rd_hit(trk_rd_hit), .any_v(trk_any),
    .wb_v(fix_v), .wb_rd(fix_rd)
  );

  fpc_wbarb u_wbarb (
    .clk(clk), .rst_n(rst_n),
    .start(accept_div), .start_rd(issue_rd), .done(div_done),
    .fix_v(fix_v), .fix_rd(fix_rd),
    .q_rs(q_rs), .q_use(issue_src_use), .q_rd(issue_rd),
    .busy(div_busy), .src_hit(div_src_hit), .rd_hit(div_rd_hit),
    .hold_v(hold_v), .collide(collide),
    .wb_en(wb_en), .wb_rd(wb_rd), .wb_from_div(wb_from_div)
  );

  fpc_hazard #(.NSRC(SRC_N)) u_hazard (
    .issue_valid(issue_valid), .kind(kind),
    .trk_src_hit(trk_src_hit), .trk_rd_hit(trk_rd_hit), .trk_any(trk_any),
    .div_src_hit(div_src_hit), .div_rd_hit(div_rd_hit), .div_busy(div_busy),
    .hold_v(hold_v), .collide(collide),
    .stall_raw(stall_raw), .stall_waw(stall_waw), .stall_move(stall_move),
    .stall_div(stall_div), .stall_wb(stall_wb), .stall(stall),
    .accept_fix(accept_fix), .accept_div(accept_div)
  );

  assign div_start = accept_div;

  // R6: a move goes only after the fixed pipe and the divider are empty
  assert_move_drained_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && kind == K_MOVE && !stall) |-> (!trk_any && !div_busy));

  // R4: no accepted FP instruction reads a pending destination
  assert_no_raw_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_fix || accept_div) |-> !(|(trk_src_hit | div_src_hit)));

  // R8: a stalled cycle leaves a bubble at the head of the fixed pipe
  assert_bubble_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && stall) |=> !u_track.pipe[0].v);

endmodule

// File: tb/tb_fp_issue_ctrl.sv
module tb_fp_issue_ctrl;

  localparam int CLK_P = 10;
  localparam int LAT   = 4;
  localparam logic [1:0] KI = 2'd0, KF = 2'd1, KD = 2'd2, KM = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic issue_valid = 1'b0;
  logic [1:0] issue_kind = 2'd0;
  logic [4:0] issue_rs1 = '0, issue_rs2 = '0, issue_rs3 = '0, issue_rd = '0;
  logic [2:0] issue_src_use = '0;
  logic div_done = 1'b0;
  logic stall, stall_raw, stall_waw, stall_move, stall_div, stall_wb;
  logic div_start, wb_en, wb_from_div;
  logic [4:0] wb_rd;

  fp_issue_ctrl #(.FIX_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_kind(issue_kind),
    .issue_rs1(issue_rs1), .issue_rs2(issue_rs2), .issue_rs3(issue_rs3),
    .issue_src_use(issue_src_use), .issue_rd(issue_rd), .div_done(div_done),
    .stall(stall), .stall_raw(stall_raw), .stall_waw(stall_waw),
    .stall_move(stall_move), .stall_div(stall_div), .stall_wb(stall_wb),
    .div_start(div_start), .wb_en(wb_en), .wb_rd(wb_rd), .wb_from_div(wb_from_div)
  );

  always #(CLK_P/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  typedef struct { int at; int rd; bit dv; } exp_t;
  exp_t sb[$];

  task automatic expect_wb(input int at, input int rd, input bit dv);
    exp_t e;
    e.at = at; e.rd = rd; e.dv = dv;
    sb.push_back(e);
  endtask

  // monitor: compares every register-file write with the scoreboard
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      int idx;
      idx = -1;
      foreach (sb[i]) if (sb[i].at == cyc) idx = i;
      if (idx >= 0) begin
        chk(wb_en == 1'b1, "R3", "write enable", int'(wb_en), 1);
        chk(int'(wb_rd) == sb[idx].rd, "R3", "write address", int'(wb_rd), sb[idx].rd);
        chk(wb_from_div == sb[idx].dv, sb[idx].dv ? "R7" : "R3", "write source",
            int'(wb_from_div), int'(sb[idx].dv));
        sb.delete(idx);
      end else if (wb_en) begin
        chk(1'b0, "R8", "unexpected write", int'(wb_rd), -1);
      end
    end
  end

  task automatic drive(input logic [1:0] k, input int r1, input int r2, input int r3,
                       input logic [2:0] use_m, input int rd, input bit done);
    @(negedge clk);
    issue_valid   = 1'b1;
    issue_kind    = k;
    issue_rs1     = 5'(r1);
    issue_rs2     = 5'(r2);
    issue_rs3     = 5'(r3);
    issue_src_use = use_m;
    issue_rd      = 5'(rd);
    div_done      = done;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      issue_valid = 1'b0;
      div_done    = 1'b0;
      #1;
    end
  endtask

  task automatic goto_cycle(input int n);
    while (cyc + 1 < n) idle(1);
  endtask

  int  st, acc_c;
  bit  s_raw, s_waw, s_mv, s_dstart;

  // present an instruction until accepted; predicts the fixed-pipe write
  task automatic issue(input logic [1:0] k, input int r1, input int r2, input int r3,
                       input logic [2:0] use_m, input int rd);
    st = 0; s_raw = 0; s_waw = 0; s_mv = 0; s_dstart = 0;
    for (int it = 0; it < 40; it++) begin
      drive(k, r1, r2, r3, use_m, rd, 1'b0);
      if (stall) begin
        st++;
        s_raw = s_raw | stall_raw;
        s_waw = s_waw | stall_waw;
        s_mv  = s_mv  | stall_move;
      end else begin
        acc_c    = cyc;
        s_dstart = div_start;
        if (k == KF) expect_wb(cyc + LAT, rd, 1'b0);
        return;
      end
    end
    chk(1'b0, "R4", "never accepted", st, 0);
  endtask

  initial begin
    #(CLK_P * 50000);
    chk(1'b0, "R1", "watchdog expired", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    chk(wb_en == 1'b0, "R1", "write after reset", int'(wb_en), 0);
    issue(KF, 0, 0, 0, 3'b111, 1);
    chk(st == 0, "R1", "stall after reset", st, 0);
    idle(LAT + 2);

    // R4: rs1 dependency on the fixed pipe
    issue(KF, 0, 0, 0, 3'b000, 5);
    issue(KF, 5, 0, 0, 3'b001, 6);
    chk(st == LAT, "R4", "rs1 stall cycles", st, LAT);
    chk(s_raw, "R4", "rs1 stall cause", int'(s_raw), 1);
    idle(LAT + 2);

    // R4: a matching but disabled source is ignored
    issue(KF, 0, 0, 0, 3'b000, 7);
    issue(KF, 0, 7, 0, 3'b001, 8);
    chk(st == 0, "R4", "disabled source stall", st, 0);
    idle(LAT + 2);

    // R4: rs3 dependency
    issue(KF, 0, 0, 0, 3'b000, 9);
    issue(KF, 0, 0, 9, 3'b100, 10);
    chk(st == LAT, "R4", "rs3 stall cycles", st, LAT);
    idle(LAT + 2);

    // R5: pending destination rewritten
    issue(KF, 0, 0, 0, 3'b000, 11);
    issue(KF, 0, 0, 0, 3'b000, 11);
    chk(st == LAT, "R5", "waw stall cycles", st, LAT);
    chk(s_waw && !s_raw, "R5", "waw cause only", int'(s_waw), 1);
    idle(LAT + 2);

    // R2: integer issue is never compared against FP destinations
    issue(KF, 0, 0, 0, 3'b000, 12);
    issue(KI, 12, 12, 12, 3'b111, 12);
    chk(st == 0, "R2", "integer stall", st, 0);
    idle(LAT + 2);

    // R6: move drains the fixed pipe
    issue(KF, 0, 0, 0, 3'b000, 13);
    issue(KM, 13, 0, 0, 3'b001, 13);
    chk(st == LAT, "R6", "move stall cycles", st, LAT);
    chk(s_mv, "R6", "move cause", int'(s_mv), 1);
    idle(LAT + 2);

    // R9: divide launch, busy and completion
    issue(KD, 0, 0, 0, 3'b000, 14);
    chk(st == 0 && s_dstart, "R9", "div_start on accept", int'(s_dstart), 1);
    drive(KD, 0, 0, 0, 3'b000, 15, 1'b0);
    chk(stall && stall_div, "R9", "second divide held", int'(stall_div), 1);
    drive(KM, 0, 0, 0, 3'b000, 1, 1'b0);
    chk(stall_move, "R6", "move waits on divider", int'(stall_move), 1);
    drive(KF, 14, 0, 0, 3'b001, 16, 1'b0);
    chk(stall_raw, "R4", "read of divide result", int'(stall_raw), 1);
    drive(KI, 0, 0, 0, 3'b000, 0, 1'b1);
    expect_wb(cyc, 14, 1'b1);
    chk(!stall, "R9", "no collision stall", int'(stall), 0);
    issue(KD, 0, 0, 0, 3'b000, 15);
    chk(st == 0, "R9", "divider free after write", st, 0);
    drive(KI, 0, 0, 0, 3'b000, 0, 1'b1);
    expect_wb(cyc, 15, 1'b1);
    idle(LAT + 2);

    // R7: collision with one fixed write
    issue(KF, 0, 0, 0, 3'b000, 20);
    t = acc_c;
    issue(KD, 0, 0, 0, 3'b000, 21);
    goto_cycle(t + LAT);
    drive(KI, 0, 0, 0, 3'b000, 0, 1'b1);
    chk(stall_wb, "R7", "collision cycle stall", int'(stall_wb), 1);
    expect_wb(t + LAT + 1, 21, 1'b1);
    drive(KI, 0, 0, 0, 3'b000, 0, 1'b0);
    chk(stall_wb, "R7", "waiting cycle stall", int'(stall_wb), 1);
    drive(KI, 0, 0, 0, 3'b000, 0, 1'b0);
    chk(!stall, "R7", "stall released", int'(stall), 0);
    idle(LAT + 2);

    // R7: collision with back-to-back fixed writes waits two cycles
    issue(KF, 0, 0, 0, 3'b000, 22);
    t = acc_c;
    issue(KF, 0, 0, 0, 3'b000, 23);
    issue(KD, 0, 0, 0, 3'b000, 24);
    goto_cycle(t + LAT);
    drive(KI, 0, 0, 0, 3'b000, 0, 1'b1);
    expect_wb(t + LAT + 2, 24, 1'b1);
    drive(KI, 0, 0, 0, 3'b000, 0, 1'b0);
    chk(stall_wb, "R7", "still waiting behind fixed", int'(stall_wb), 1);
    idle(LAT + 3);

    chk(sb.size() == 0, "R3", "predicted writes missing", sb.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule